// File: doc/BRIEF.md
# Memory Self-Test Controller with Single-Word Repair

This block tests one single-port SRAM of 16-bit words. The SRAM writes when its write enable is low. The block also keeps a record of the outcome. Software reaches it through a small Wishbone-style register slave and follows three steps:

1. Set the reset-release bits.
2. Set the enable and run bits.
3. Poll a status byte until its completion flag rises.

While a test runs, the block drives the address, write data and write enable of the memory. It compares each word read back against the value it expects. The test is a March C- pattern with six elements, run in this order:

- write 0 ascending;
- read 0 / write 1 ascending;
- read 1 / write 0 ascending;
- read 0 / write 1 descending;
- read 1 / write 0 descending;
- a final read-0 pass, ascending.

A mismatch is counted. The first failing address is captured in a single repair entry, and from then on a spare register stands in for that word. A mismatch at any other address is fatal. The status therefore separates three outcomes: a clean part, a part saved by the repair, and a part that cannot be repaired.

Top module: `mbist_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the following all hold:
  - `wb_ack` is 0.
  - `mem_web` is 1.
  - `host_rst_n` is 0.
  - The registers at offsets 0x4, 0x8 and 0xC all read 0.
- R2: Bus access and register map:
  - A request (`wb_cyc` and `wb_stb` high) is acknowledged one cycle later, for exactly one cycle.
  - Writes to offset 0x4 and offset 0x8 read back unchanged.
  - Any other offset except 0xC reads 0.
  - `host_rst_n` follows bit 0 of offset 0x4.
- R3: A test starts only when all three of these bits are 1: bit 1 of offset 0x4 (self-test reset released), bit 0 of offset 0x8 (enable) and bit 1 of offset 0x8 (run). Otherwise `mem_web` stays 1.
- R4: The status byte at offset 0xC is laid out as follows:
  - bit 0: done;
  - bit 1: fatal error;
  - bit 2: repaired;
  - bits 6:3: failure count.
- R5: A run on a fault-free memory ends with status 0x01.
- R6: A run in which exactly one address returns a single-bit mismatch ends with status 0x0D: done, repaired, count 1, no error.
- R7: A mismatch at a second, distinct address sets the error bit.
  - Case: 0x10 and 0x20 are both stuck at 0 in bit 0. The run ends with status 0x1F (count 3).
- R8: The failure count saturates at 15.
  - Case: 32 addresses are stuck at 0 in bit 0. The run ends with status 0x7F.
- R9: A failing comparison captures its address in the repair entry. From the following cycle on, writes to that address are held off the memory (`mem_web` stays 1) and go to the spare instead.
  - Case: when only 0x10 fails, the memory sees 3 writes to 0x10 per run.
  - Case: an unrepaired address sees 5 writes per run.
- R10: The elements run in the order given above, with 2^AW words each.
  - A write-only element takes 1 cycle per word.
  - A read element takes 2 cycles per word: the read is issued, then the compare happens in the same cycle as the write.
  - A full run therefore issues 5·2^AW writes. Done rises 11·2^AW + 1 cycles after start.
- R11: Any of the following returns the controller to idle, with the status and the repair entry cleared: clearing enable or run, or setting bit 1 of offset 0x4 back to 0.
- R12: Once done, the controller holds its status and issues no further memory access for as long as its start conditions remain set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write (1) or read (0) |
| wb_adr | input | BUS_AW | Byte offset of the register |
| wb_wdata | input | BUS_DW | Write data |
| wb_rdata | output | BUS_DW | Read data, valid with wb_ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| host_rst_n | output | 1 | Bus-side reset release, bit 0 of offset 0x4 |
| mem_addr | output | AW | Memory word address |
| mem_din | output | DW | Data written to memory |
| mem_web | output | 1 | Memory write enable, active low |
| mem_rdata | input | DW | Memory read data, one cycle after the address |

## Verification
The bound checker enforces several rules on every clock:
- the acknowledge is a single pulse, and only follows a request;
- the memory is never written outside a run;
- a cleared start condition empties the status;
- a saturated count stays at 15;
- the error bit never appears without a repair;
- done holds while the start conditions stay set.

Only the bench can show the end-to-end results, because they need a faulty memory model. These are the exact status bytes for clean, single-fault, double-fault and many-fault memories, and faults at the address extremes. They also include the number of memory writes that reach a repaired word, the total write count and run length, and the cleared repair entry seen in the run that follows.

// File: rtl/mbist_pkg.sv
// mbist_pkg: shared encodings for the memory self-test controller.
// Holds register offsets, the status byte layout and the March C- element
// table, expressed as small functions so the sequencer stays generic.
package mbist_pkg;

    localparam int CNT_W = 4;

    localparam logic [3:0] OFS_RST  = 4'h4;
    localparam logic [3:0] OFS_CTRL = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;

    // Status byte: count in [6:3], repaired [2], error [1], done [0].
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             corr;
        logic             err;
        logic             done;
    } mbist_stat_t;

    typedef enum logic [2:0] {
        EL_W0_UP   = 3'd0,
        EL_R0W1_UP = 3'd1,
        EL_R1W0_UP = 3'd2,
        EL_R0W1_DN = 3'd3,
        EL_R1W0_DN = 3'd4,
        EL_R0_UP   = 3'd5
    } march_el_e;

    function automatic logic el_reads(input march_el_e e);
        return e != EL_W0_UP;
    endfunction

    function automatic logic el_writes(input march_el_e e);
        return e != EL_R0_UP;
    endfunction

    function automatic logic el_rbit(input march_el_e e);
        return (e == EL_R1W0_UP) || (e == EL_R1W0_DN);
    endfunction

    function automatic logic el_wbit(input march_el_e e);
        return (e == EL_R0W1_UP) || (e == EL_R0W1_DN);
    endfunction

    function automatic logic el_down(input march_el_e e);
        return (e == EL_R0W1_DN) || (e == EL_R1W0_DN);
    endfunction

    function automatic march_el_e el_next(input march_el_e e);
        case (e)
            EL_W0_UP:   return EL_R0W1_UP;
            EL_R0W1_UP: return EL_R1W0_UP;
            EL_R1W0_UP: return EL_R0W1_DN;
            EL_R0W1_DN: return EL_R1W0_DN;
            default:    return EL_R0_UP;
        endcase
    endfunction

endpackage

// File: rtl/mbist_regs.sv
// mbist_regs: Wishbone-style register slave.
// Assumes single-beat accesses; every request is acknowledged one cycle
// later for one cycle. Offsets 0x4 and 0x8 are full-width read/write
// registers of which only bits [1:0] carry meaning; 0xC is read-only status.
module mbist_regs
    import mbist_pkg::*;
#(
    parameter int BUS_AW = 4,
    parameter int BUS_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [BUS_AW-1:0] wb_adr,
    input  logic [BUS_DW-1:0] wb_wdata,
    output logic [BUS_DW-1:0] wb_rdata,
    output logic              wb_ack,
    input  mbist_stat_t       stat_i,
    output logic              host_rst_n,
    output logic              bist_go
);
    localparam int STAT_W = $bits(mbist_stat_t);

    logic [BUS_DW-1:0] rst_reg;
    logic [BUS_DW-1:0] ctrl_reg;
    logic              req;

    assign req = wb_cyc && wb_stb && !wb_ack;

    // Acknowledge pulse, one cycle after each new request.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_ack <= 1'b0;
        else        wb_ack <= req;
    end

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_reg  <= '0;
            ctrl_reg <= '0;
        end else if (req && wb_we) begin
            if (wb_adr == BUS_AW'(OFS_RST))  rst_reg  <= wb_wdata;
            if (wb_adr == BUS_AW'(OFS_CTRL)) ctrl_reg <= wb_wdata;
        end
    end

    // Registered read data; unmapped offsets return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_rdata <= '0;
        end else if (req) begin
            if (wb_adr == BUS_AW'(OFS_RST))       wb_rdata <= rst_reg;
            else if (wb_adr == BUS_AW'(OFS_CTRL)) wb_rdata <= ctrl_reg;
            else if (wb_adr == BUS_AW'(OFS_STAT)) wb_rdata <= {{(BUS_DW-STAT_W){1'b0}}, stat_i};
            else                                  wb_rdata <= '0;
        end
    end

    assign host_rst_n = rst_reg[0];
    assign bist_go    = rst_reg[1] && ctrl_reg[0] && ctrl_reg[1];

endmodule

// File: rtl/mbist_seq.sv
// mbist_seq: March C- address and operation sequencer.
// Assumes a memory with one cycle of read latency. Read elements use two
// cycles per word (issue read, then compare and write); the write-only
// element uses one. Dropping go returns it to idle at once.
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [AW-1:0] op_addr,
    output logic          op_we,
    output logic [DW-1:0] op_wdata,
    output logic          cmp_en,
    output logic [DW-1:0] cmp_exp,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] MAXA = {AW{1'b1}};

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} sq_state_e;

    sq_state_e     st;
    march_el_e     el;
    logic          phase;
    logic [AW-1:0] addr;
    logic          last_addr;

    assign last_addr = el_down(el) ? (addr == '0) : (addr == MAXA);

    // Element, address and phase stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            st    <= SQ_IDLE;
            el    <= EL_W0_UP;
            phase <= 1'b0;
            addr  <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    st    <= SQ_RUN;
                    el    <= EL_W0_UP;
                    phase <= 1'b0;
                    addr  <= '0;
                end
                SQ_RUN: begin
                    if (el_reads(el) && !phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        if (!last_addr) begin
                            addr <= el_down(el) ? addr - 1'b1 : addr + 1'b1;
                        end else if (el == EL_R0_UP) begin
                            st <= SQ_DONE;
                        end else begin
                            el   <= el_next(el);
                            addr <= el_down(el_next(el)) ? MAXA : '0;
                        end
                    end
                end
                default: st <= SQ_DONE;
            endcase
        end
    end

    // Operation decode for the current cycle.
    always_comb begin
        busy     = (st == SQ_RUN);
        done     = (st == SQ_DONE);
        op_addr  = addr;
        op_we    = busy && el_writes(el) && (!el_reads(el) || phase);
        op_wdata = {DW{el_wbit(el)}};
        cmp_en   = busy && el_reads(el) && phase;
        cmp_exp  = {DW{el_rbit(el)}};
    end

endmodule

// File: rtl/mbist_repair.sv
// mbist_repair: compare, single-entry repair and failure accounting.
// The first failing address is captured together with a spare word; later
// accesses to it are served by the spare. Failures elsewhere are fatal.
// clr returns all state to empty.
module mbist_repair
    import mbist_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [AW-1:0]    op_addr,
    input  logic             op_we,
    input  logic [DW-1:0]    op_wdata,
    input  logic             cmp_en,
    input  logic [DW-1:0]    cmp_exp,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_din,
    output logic             mem_web,
    output logic [CNT_W-1:0] fail_cnt,
    output logic             fail_err,
    output logic             fail_corr
);
    logic          rep_vld;
    logic [AW-1:0] rep_addr;
    logic [DW-1:0] spare;
    logic          hit;
    logic          mism;

    assign hit      = rep_vld && (rep_addr == op_addr);
    assign mism     = cmp_en && ((hit ? spare : mem_rdata) != cmp_exp);
    assign mem_addr = op_addr;
    assign mem_din  = op_wdata;
    assign mem_web  = !(op_we && !hit);

    // Repair entry, spare word and status accounting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rep_vld   <= 1'b0;
            rep_addr  <= '0;
            spare     <= '0;
            fail_cnt  <= '0;
            fail_err  <= 1'b0;
            fail_corr <= 1'b0;
        end else begin
            if (hit && op_we) spare <= op_wdata;
            if (mism) begin
                if (fail_cnt != {CNT_W{1'b1}}) fail_cnt <= fail_cnt + 1'b1;
                if (!rep_vld) begin
                    rep_vld   <= 1'b1;
                    rep_addr  <= op_addr;
                    spare     <= op_we ? op_wdata : cmp_exp;
                    fail_corr <= 1'b1;
                end else if (!hit) begin
                    fail_err  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mbist_ctrl.sv
// mbist_ctrl: top of the memory self-test controller.
// Ties the register slave, the March sequencer and the repair/compare unit
// together. Assumes an external single-port SRAM with one-cycle read latency
// and an active-low write enable.
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 16,
    parameter int BUS_AW = 4,
    parameter int BUS_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [BUS_AW-1:0] wb_adr,
    input  logic [BUS_DW-1:0] wb_wdata,
    output logic [BUS_DW-1:0] wb_rdata,
    output logic              wb_ack,
    output logic              host_rst_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_din,
    output logic              mem_web,
    input  logic [DW-1:0]     mem_rdata
);
    logic             bist_go;
    logic             seq_busy;
    logic             seq_done;
    logic [AW-1:0]    op_addr;
    logic             op_we;
    logic [DW-1:0]    op_wdata;
    logic             cmp_en;
    logic [DW-1:0]    cmp_exp;
    logic [CNT_W-1:0] rep_cnt;
    logic             rep_err;
    logic             rep_corr;
    mbist_stat_t      stat;

    assign stat = '{cnt: rep_cnt, corr: rep_corr, err: rep_err, done: seq_done};

    mbist_regs #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_wdata(wb_wdata), .wb_rdata(wb_rdata), .wb_ack(wb_ack),
        .stat_i(stat), .host_rst_n(host_rst_n), .bist_go(bist_go)
    );

    mbist_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(bist_go),
        .op_addr(op_addr), .op_we(op_we), .op_wdata(op_wdata),
        .cmp_en(cmp_en), .cmp_exp(cmp_exp), .busy(seq_busy), .done(seq_done)
    );

    mbist_repair #(.AW(AW), .DW(DW)) u_rep (
        .clk(clk), .rst_n(rst_n), .clr(!bist_go),
        .op_addr(op_addr), .op_we(op_we), .op_wdata(op_wdata),
        .cmp_en(cmp_en), .cmp_exp(cmp_exp), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_din(mem_din), .mem_web(mem_web),
        .fail_cnt(rep_cnt), .fail_err(rep_err), .fail_corr(rep_corr)
    );

endmodule

// File: rtl/mbist_ctrl_chk.sv
// mbist_ctrl_chk: protocol and status invariants, bound into mbist_ctrl.
module mbist_ctrl_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_ack,
    input logic             mem_web,
    input logic             go,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             corr,
    input logic [CNT_W-1:0] cnt
);
    // R2: acknowledge lasts exactly one cycle
    a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);
    // R2: acknowledge only answers a request
    a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_cyc && wb_stb));
    // R3: no memory write outside a run
    a_r3_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mem_web);
    // R3: no run without the start conditions
    a_r3_no_run_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !busy);
    // R7: a fatal error implies a repair was already taken
    a_r7_err_needs_repair: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> corr);
    // R8: a saturated count stays saturated
    a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt == {CNT_W{1'b1}}) |=> cnt == {CNT_W{1'b1}});
    // R11: dropping the start conditions empties the status
    a_r11_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (cnt == '0 && !err && !corr && !done));
    // R12: done holds while the start conditions stay set
    a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> (done && !busy));
endmodule

bind mbist_ctrl mbist_ctrl_chk #(.CNT_W(mbist_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_ack(wb_ack), .mem_web(mem_web), .go(bist_go), .busy(seq_busy),
    .done(seq_done), .err(rep_err), .corr(rep_corr), .cnt(rep_cnt)
);

// File: tb/sim_mbist_ctrl.sv
// sim_mbist_ctrl: self-checking bench with a faulty-SRAM model.
module sim_mbist_ctrl;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [3:0]    wb_adr = '0;
    logic [7:0]    wb_wdata = '0;
    logic [7:0]    wb_rdata;
    logic          wb_ack;
    logic          host_rst_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_din;
    logic          mem_web;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    mbist_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_wdata(wb_wdata),
        .wb_rdata(wb_rdata), .wb_ack(wb_ack), .host_rst_n(host_rst_n),
        .mem_addr(mem_addr), .mem_din(mem_din), .mem_web(mem_web),
        .mem_rdata(mem_rdata)
    );

    // SRAM model: addresses in [lo1,hi1] or [lo2,hi2] have bit 0 stuck at 0.
    logic [DW-1:0] mem [NW];
    int lo1 = 1, hi1 = 0, lo2 = 1, hi2 = 0;
    int cyc_n = 0, n_wr = 0, n_w16 = 0;
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    function automatic bit faulty(input int a);
        return (a >= lo1 && a <= hi1) || (a >= lo2 && a <= hi2);
    endfunction

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (!mem_web) begin
            mem[mem_addr] <= faulty(int'(mem_addr)) ? (mem_din & 16'hFFFE) : mem_din;
            n_wr <= n_wr + 1;
            if (mem_addr == AW'(16)) n_w16 <= n_w16 + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wb_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_wdata = d;
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
    endtask

    task automatic wb_rd(input logic [3:0] a, output logic [7:0] d, output logic ack);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
        @(negedge clk);
        d = wb_rdata; ack = wb_ack;
        wb_cyc = 0; wb_stb = 0;
    endtask

    task automatic wait_done(output logic [7:0] st);
        logic ak;
        st = '0;
        while (!st[0]) wb_rd(4'hC, st, ak);
    endtask

    // Fault table: {lo1, hi1, lo2, hi2, expected status, expected writes at 0x10}
    typedef struct packed {
        logic [9:0] l1, h1, l2, h2;
        logic [7:0] est;
        logic [3:0] ew16;
    } row_t;
    localparam row_t ROWS [6] = '{
        '{10'd1,   10'd0,    10'd1,  10'd0,  8'h01, 4'd5},  // R5 clean
        '{10'd16,  10'd16,   10'd1,  10'd0,  8'h0D, 4'd3},  // R6 single at 0x10
        '{10'd16,  10'd16,   10'd32, 10'd32, 8'h1F, 4'd3},  // R7 two addresses
        '{10'd64,  10'd95,   10'd1,  10'd0,  8'h7F, 4'd5},  // R8 saturation
        '{10'd0,   10'd0,    10'd1,  10'd0,  8'h0D, 4'd5},  // R6 lowest address
        '{10'd1023,10'd1023, 10'd1,  10'd0,  8'h0D, 4'd5}   // R6 highest address
    };
    localparam string TAGS [6] = '{"R5 R4 clean", "R6 R4 single", "R7 R4 second addr",
                                   "R8 R4 saturate", "R6 addr 0", "R6 top addr"};

    initial begin
        logic [7:0] d;
        logic       ak;
        int t0, w0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 ack", wb_ack, 0);
        chk("R1 web", mem_web, 1);
        chk("R1 host_rst_n", host_rst_n, 0);
        rst_n = 1;
        wb_rd(4'h4, d, ak); chk("R1 rst reg", d, 0);
        wb_rd(4'h8, d, ak); chk("R1 ctrl reg", d, 0);
        wb_rd(4'hC, d, ak); chk("R1 status", d, 0);
        // R2: register access and acknowledge
        wb_wr(4'h4, 8'h01);
        wb_rd(4'h4, d, ak); chk("R2 rst readback", d, 8'h01); chk("R2 ack", ak, 1);
        @(negedge clk); chk("R2 ack single", wb_ack, 0);
        chk("R2 host_rst_n", host_rst_n, 1);
        wb_wr(4'h8, 8'h5A);
        wb_rd(4'h8, d, ak); chk("R2 ctrl readback", d, 8'h5A);
        wb_rd(4'h0, d, ak); chk("R2 unmapped 0x0", d, 0);
        wb_rd(4'h6, d, ak); chk("R2 unmapped 0x6", d, 0);
        // R3: enable and run set but self-test reset still asserted
        w0 = n_wr;
        wb_wr(4'h8, 8'h03);
        repeat (40) @(negedge clk);
        chk("R3 no writes in reset", n_wr - w0, 0);
        wb_rd(4'hC, d, ak); chk("R3 status idle", d, 0);
        // R3: reset released, run clear
        wb_wr(4'h8, 8'h01);
        wb_wr(4'h4, 8'h03);
        repeat (40) @(negedge clk);
        chk("R3 no writes without run", n_wr - w0, 0);

        // Table of fault patterns, one full run each.
        for (int i = 0; i < 6; i++) begin
            wb_wr(4'h8, 8'h00);
            lo1 = ROWS[i].l1; hi1 = ROWS[i].h1; lo2 = ROWS[i].l2; hi2 = ROWS[i].h2;
            wb_rd(4'hC, d, ak); chk("R11 cleared before run", d, 0);
            @(negedge clk);
            w0 = n_wr; n_w16 = 0;
            wb_wr(4'h8, 8'h03);
            t0 = cyc_n;
            wait_done(d);
            chk(TAGS[i], d, ROWS[i].est);
            chk("R9 writes at 0x10", n_w16, ROWS[i].ew16);
            if (i == 0) begin
                chk("R10 write count", n_wr - w0, 5 * NW);
                chk("R10 not early", (cyc_n - t0) >= 11 * NW + 1, 1);
                chk("R10 not late", (cyc_n - t0) <= 11 * NW + 20, 1);
            end
        end

        // R12: completed run holds, no more accesses
        w0 = n_wr;
        repeat (100) @(negedge clk);
        chk("R12 no accesses after done", n_wr - w0, 0);
        wb_rd(4'hC, d, ak); chk("R12 status held", d, 8'h0D);

        // R11: reset bit clears status, release restarts with fresh repair
        wb_wr(4'h8, 8'h00);
        lo1 = 16; hi1 = 16; lo2 = 1; hi2 = 0;
        wb_wr(4'h8, 8'h03);
        wait_done(d); chk("R6 repeat single", d, 8'h0D);
        wb_wr(4'h4, 8'h01);
        wb_rd(4'hC, d, ak); chk("R11 bist reset clears", d, 0);
        lo1 = 1; hi1 = 0;
        n_w16 = 0;
        wb_wr(4'h4, 8'h03);
        wait_done(d);
        chk("R11 clean after reset", d, 8'h01);
        chk("R11 repair entry cleared", n_w16, 5);

        // R11: abort by clearing enable mid-run
        wb_wr(4'h8, 8'h00);
        wb_wr(4'h8, 8'h03);
        repeat (200) @(negedge clk);
        wb_wr(4'h8, 8'h02);
        wb_rd(4'hC, d, ak); chk("R11 abort status", d, 0);
        w0 = n_wr;
        repeat (30) @(negedge clk);
        chk("R11 abort stops writes", n_wr - w0, 0);
        chk("R11 abort web high", mem_web, 1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule